// File: doc/BRIEF.md
# Banked Data Register File with Pointer Indirection

This block is the data-memory side of a small 8-bit accumulator core. An instruction carries only a 7-bit file field. The block extends that field to a 9-bit data address by putting two bank-select bits from its own status register above it. This direct mode reaches four banks of 128 bytes each. Three file addresses are special, and they decode to the same thing in every bank:

- File address 0x00 has no storage of its own. Any access to it is redirected to the location named by a 9-bit indirect address. That address is the status pointer-extension bit (bit 7) placed above the 8-bit pointer register.
- File address 0x03 is the status register itself.
- File address 0x04 is the pointer register.

Reads are combinational from the composed address. Writes land on the rising clock edge. The core can therefore read a location, modify the value and write it back within one cycle. Behind the special registers sits a 512-byte store that covers the full 9-bit space. The block has no sequencing state: every access completes in the cycle it is presented. The only clocked elements are the status register, the pointer register and the store.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous reset clears the status register and the pointer register, so that reads of file addresses 0x03 and 0x04 return 0x00 in the first cycle after reset.
- R2: For a file address other than 0x00, 0x03 and 0x04, the data address is {status bit 6, status bit 5, file address}. Bank 0 is both bits clear, bank 1 is bit 5 alone, bank 2 is bit 6 alone and bank 3 is both set. Each of the 4 x 125 such locations holds its own byte.
- R3: File address 0x03 reads and writes the status register, and 0x04 reads and writes the pointer register, whatever the bank bits are.
- R4: An access to file address 0x00 reads or writes the location whose 9-bit address is {status bit 7, pointer[7:0]}. A value written this way is seen by a direct access to the same 9-bit address, and the reverse also holds.
- R5: When pointer[6:0] is 0x00, a read at file address 0x00 returns 0x00 and a write there changes neither status, pointer nor any stored byte.
- R6: Read data follows the composed address combinationally and is not affected by wr_data within the cycle. A write takes effect at the rising edge, so a value read, changed and written in one cycle is read back in the next cycle.
- R7: Status bit 7 and status bits 4..0 have no effect on direct addressing. The bank bits (6 and 5) have no effect on indirect addressing.
- R8: When pointer[6:0] is 0x03 or 0x04, an access at file address 0x00 reaches the status or the pointer register respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes occur on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| file_addr | input | 7 | File address field from the instruction |
| wr_en | input | 1 | Write strobe for the current access |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Byte at the composed address (combinational) |

## Verification
A corrupted bank bit shows up as soon as the next direct read returns the byte of a neighbouring bank. Because the read path is combinational, the error appears in the same cycle the address is presented. A wrong pointer or pointer-extension bit shows up on the very next access at file address 0x00. A write that lands in the wrong place, or not at all, shows up on the readback one edge later. The sweeps therefore fill every location with a value derived from its own 9-bit address, so that any aliasing between banks or between the two addressing modes returns a value that can be told apart from the expected one.

// File: rtl/bfr_pkg.sv
package bfr_pkg;

    // Where a composed access lands.
    typedef enum logic [1:0] {
        TGT_RAM    = 2'd0,
        TGT_STATUS = 2'd1,
        TGT_PTR    = 2'd2,
        TGT_NULL   = 2'd3
    } bfr_tgt_e;

endpackage

// File: rtl/bfr_addr_map.sv
module bfr_addr_map
    import bfr_pkg::*;
#(
    parameter int FADDR_W = 7,
    parameter int BANK_W  = 2,
    parameter int DATA_W  = 8,
    parameter logic [FADDR_W-1:0] IND_ADDR  = 7'h00,
    parameter logic [FADDR_W-1:0] STAT_ADDR = 7'h03,
    parameter logic [FADDR_W-1:0] PTR_ADDR  = 7'h04,
    localparam int FULL_W = FADDR_W + BANK_W
) (
    input  logic [FADDR_W-1:0] file_addr,
    input  logic [BANK_W-1:0]  bank_sel,
    input  logic               ptr_ext,
    input  logic [DATA_W-1:0]  ptr_val,
    output logic [FULL_W-1:0]  eff_addr,
    output bfr_tgt_e           tgt
);

    logic               use_ind;
    logic [FULL_W-1:0]  ind_addr;
    logic [FULL_W-1:0]  dir_addr;
    logic [FADDR_W-1:0] low_addr;

    always_comb begin
        use_ind  = (file_addr == IND_ADDR);
        ind_addr = FULL_W'({ptr_ext, ptr_val});
        dir_addr = {bank_sel, file_addr};
        eff_addr = use_ind ? ind_addr : dir_addr;
        low_addr = eff_addr[FADDR_W-1:0];
    end

    // Special registers decode on the low field alone, in every bank.
    always_comb begin
        if (low_addr == IND_ADDR) begin
            tgt = TGT_NULL;
        end else if (low_addr == STAT_ADDR) begin
            tgt = TGT_STATUS;
        end else if (low_addr == PTR_ADDR) begin
            tgt = TGT_PTR;
        end else begin
            tgt = TGT_RAM;
        end
    end

endmodule

// File: rtl/bfr_ctrl_regs.sv
module bfr_ctrl_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_status,
    input  logic              wr_ptr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] status_q,
    output logic [DATA_W-1:0] ptr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            ptr_q    <= '0;
        end else begin
            if (wr_status) begin
                status_q <= wdata;
            end
            if (wr_ptr) begin
                ptr_q <= wdata;
            end
        end
    end

    // R1: both registers are clear in the first cycle after reset
    assert_reset_clear_R1: assert property (
        @(posedge clk) disable iff (rst)
        $past(rst) |-> (status_q == '0 && ptr_q == '0)
    );

endmodule

// File: rtl/bfr_store.sv
module bfr_store #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

    // R6: a write is visible at its address after the edge
    assert_write_lands_R6: assert property (
        @(posedge clk) disable iff (rst)
        we |=> (mem[$past(addr)] == $past(wdata))
    );

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import bfr_pkg::*;
#(
    parameter int FADDR_W  = 7,
    parameter int BANK_W   = 2,
    parameter int DATA_W   = 8,
    parameter int BANK_LSB = 5,
    parameter int PTR_HI   = 7,
    parameter logic [FADDR_W-1:0] IND_ADDR  = 7'h00,
    parameter logic [FADDR_W-1:0] STAT_ADDR = 7'h03,
    parameter logic [FADDR_W-1:0] PTR_ADDR  = 7'h04
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [FADDR_W-1:0] file_addr,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data
);

    localparam int FULL_W = FADDR_W + BANK_W;

    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] ptr_q;
    logic [FULL_W-1:0] eff_addr;
    bfr_tgt_e          tgt;
    logic [DATA_W-1:0] ram_rdata;
    logic              wr_status;
    logic              wr_ptr;
    logic              ram_we;

    bfr_addr_map #(
        .FADDR_W  (FADDR_W),
        .BANK_W   (BANK_W),
        .DATA_W   (DATA_W),
        .IND_ADDR (IND_ADDR),
        .STAT_ADDR(STAT_ADDR),
        .PTR_ADDR (PTR_ADDR)
    ) u_map (
        .file_addr(file_addr),
        .bank_sel (status_q[BANK_LSB +: BANK_W]),
        .ptr_ext  (status_q[PTR_HI]),
        .ptr_val  (ptr_q),
        .eff_addr (eff_addr),
        .tgt      (tgt)
    );

    always_comb begin
        wr_status = wr_en && (tgt == TGT_STATUS);
        wr_ptr    = wr_en && (tgt == TGT_PTR);
        ram_we    = wr_en && (tgt == TGT_RAM);
    end

    bfr_ctrl_regs #(
        .DATA_W(DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_status(wr_status),
        .wr_ptr   (wr_ptr),
        .wdata    (wr_data),
        .status_q (status_q),
        .ptr_q    (ptr_q)
    );

    bfr_store #(
        .ADDR_W(FULL_W),
        .DATA_W(DATA_W)
    ) u_store (
        .clk  (clk),
        .rst  (rst),
        .we   (ram_we),
        .addr (eff_addr),
        .wdata(wr_data),
        .rdata(ram_rdata)
    );

    always_comb begin
        unique case (tgt)
            TGT_RAM:    rd_data = ram_rdata;
            TGT_STATUS: rd_data = status_q;
            TGT_PTR:    rd_data = ptr_q;
            TGT_NULL:   rd_data = '0;
        endcase
    end

    // R3: the status alias reads the live register in any bank
    assert_status_alias_R3: assert property (
        @(posedge clk) disable iff (rst)
        (file_addr == STAT_ADDR) |-> (rd_data == status_q)
    );

    // R5: a self-referencing indirect write leaves both registers alone
    assert_null_write_R5: assert property (
        @(posedge clk) disable iff (rst)
        (wr_en && file_addr == IND_ADDR && ptr_q[FADDR_W-1:0] == IND_ADDR)
            |=> ($stable(status_q) && $stable(ptr_q))
    );

    // R8: indirection onto the pointer slot returns the pointer itself
    assert_ind_to_ptr_R8: assert property (
        @(posedge clk) disable iff (rst)
        (file_addr == IND_ADDR && ptr_q[FADDR_W-1:0] == PTR_ADDR)
            |-> (rd_data == ptr_q)
    );

endmodule

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic       clk = 1'b0;
    logic       rst;
    logic [6:0] file_addr;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    banked_regfile u_dut (
        .clk      (clk),
        .rst      (rst),
        .file_addr(file_addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] pat(input int a, input int salt);
        return 8'((a * 7 + (a >> 8) * 93 + salt * 41) & 255);
    endfunction

    function automatic bit is_special(input int low);
        return (low == 0) || (low == 3) || (low == 4);
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        file_addr = a;
        wr_data   = d;
        wr_en     = 1'b1;
        @(negedge clk);
        wr_en     = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [6:0] a, input logic [7:0] exp);
        file_addr = a;
        wr_en     = 1'b0;
        #1;
        check(tag, rd_data, exp);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG_CYCLES);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] old;
        rst = 1'b1; file_addr = '0; wr_en = 1'b0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd_chk("R1 status", 7'h03, 8'h00);
        rd_chk("R1 pointer", 7'h04, 8'h00);
        // R5: pointer 0 after reset -> indirect reads zero
        rd_chk("R5 null read after reset", 7'h00, 8'h00);

        // R2: fill every direct location in all four banks, then read back
        for (int b = 0; b < 4; b++) begin
            wr(7'h03, 8'(b << 5));
            for (int f = 1; f < 128; f++) begin
                if (!is_special(f)) wr(7'(f), pat(b * 128 + f, 1));
            end
        end
        for (int b = 0; b < 4; b++) begin
            wr(7'h03, 8'(b << 5));
            for (int f = 1; f < 128; f++) begin
                if (!is_special(f)) rd_chk("R2 direct bank read", 7'(f), pat(b * 128 + f, 1));
            end
        end

        // R4/R7: indirect read of direct data with arbitrary bank bits, then indirect write
        for (int a = 0; a < 512; a++) begin
            if (!is_special(a & 127)) begin
                wr(7'h03, {1'(a >> 8), 2'(a), 5'b01010});
                wr(7'h04, 8'(a));
                rd_chk("R4 indirect read", 7'h00, pat(a, 1));
                wr(7'h00, pat(a, 2));
            end
        end
        // R4/R7: direct readback of indirect writes with IRP and low bits scrambled
        for (int a = 0; a < 512; a++) begin
            if (!is_special(a & 127)) begin
                wr(7'h03, {~1'(a >> 8), 2'(a >> 7), 5'b10101});
                rd_chk("R7 direct ignores other status bits", 7'(a), pat(a, 2));
            end
        end

        // R3: special registers alias in every bank
        wr(7'h03, 8'h60);
        wr(7'h04, 8'h5C);
        rd_chk("R3 status in bank3", 7'h03, 8'h60);
        wr(7'h03, 8'h00);
        rd_chk("R3 pointer seen from bank0", 7'h04, 8'h5C);
        wr(7'h03, 8'h40);
        rd_chk("R3 status in bank2", 7'h03, 8'h40);

        // R5: self-referencing pointer, IRP set
        wr(7'h03, 8'h80);
        wr(7'h04, 8'h80);
        rd_chk("R5 null read", 7'h00, 8'h00);
        wr(7'h00, 8'h5A);
        rd_chk("R5 status unchanged", 7'h03, 8'h80);
        rd_chk("R5 pointer unchanged", 7'h04, 8'h80);
        wr(7'h03, 8'h00);
        rd_chk("R5 neighbour byte unchanged", 7'h01, pat(1, 2));

        // R8: indirection onto status and pointer
        wr(7'h03, 8'h20);
        wr(7'h04, 8'h03);
        rd_chk("R8 indirect status read", 7'h00, 8'h20);
        wr(7'h00, 8'h40);
        rd_chk("R8 indirect status write", 7'h03, 8'h40);
        wr(7'h03, 8'h00);
        wr(7'h04, 8'h84);
        rd_chk("R8 indirect pointer read", 7'h00, 8'h84);
        wr(7'h00, 8'h11);
        rd_chk("R8 indirect pointer write", 7'h04, 8'h11);

        // R6: read-modify-write in one cycle
        wr(7'h03, 8'h00);
        @(negedge clk);
        file_addr = 7'h20;
        #1;
        old = rd_data;
        check("R6 pre-read", old, pat(32, 2));
        wr_data = old + 8'd1;
        wr_en   = 1'b1;
        #1;
        check("R6 no write-through before edge", rd_data, old);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        check("R6 value after edge", rd_data, old + 8'd1);

        // R1: reset mid-run clears status and pointer
        wr(7'h03, 8'hE5);
        wr(7'h04, 8'h77);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd_chk("R1 status after reset", 7'h03, 8'h00);
        rd_chk("R1 pointer after reset", 7'h04, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule